// File: doc/BRIEF.md
# Reply Frame Transmitter

This block turns a finished memory access into a reply frame and sends it to the host over a serial line that several memory nodes share. A request carries either a read completion with a byte count, or a check-error indication. The block latches the request, marks itself busy and drives the line low for one bit time as a start condition. It then shifts out the frame bytes back to back, each byte least significant bit first, at a bit rate set by a clock divider parameter. When the last bit has been sent it stops driving the line, so another node can use it.

A frame begins with the node's own address, followed by a type byte and a four-byte count. For a read completion the data bytes come next. They are fetched one at a time from an external buffer through an index and a read strobe. For an error reply the count is zero and a single zero byte stands in for the data, so every frame has the same shape. An 8-bit CRC closes the frame. It uses the polynomial x^8+x^5+x^4+1 (0x31), starts from 0x00, and covers every byte from the address through the last data byte.

Top module: `rspTx`

## Requirements
- R1: The first frame byte equals `nodeAddr` as sampled in the cycle the request is accepted; later changes to `nodeAddr` do not alter the frame in flight.
- R2: The second byte is 0xAA for a read reply and 0xF0 for an error reply. When `sendReq` and `errReq` are both high in the accepting cycle, an error reply is sent.
- R3: In a read reply, bytes 2 to 5 carry `reqLen` as a 32-bit value, most significant byte first. They are followed by `reqLen` data bytes. Data byte k is the value on `bufData` in the cycle where `bufRd` is high and `bufIdx` equals k, and the bytes are read in order k = 0, 1, 2 and so on.
- R4: In an error reply, bytes 2 to 5 are 0x00 and exactly one 0x00 data byte follows, so the frame is 8 bytes long.
- R5: The final byte is a CRC-8 over every byte from the address through the last data byte. It uses polynomial 0x31 and initial value 0x00, is not reflected, and feeds each byte most significant bit first.
- R6: In the cycle after acceptance the line is driven low for CLKS_PER_BIT cycles as the start condition. Frame bits follow without gaps, each byte least significant bit first, and every bit is held for exactly CLKS_PER_BIT cycles.
- R7: After the last CRC bit, `txDrive` falls, `txLine` goes to high impedance and `busy` falls, all in the same cycle.
- R8: `busy` rises only in the cycle after a request is accepted and stays high until the line is released. Requests that arrive while `busy` is high are ignored and start no frame.
- R9: A `sendReq` with `reqLen` of 0 or above MAX_LEN (232) is ignored: no frame starts and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nodeAddr | input | 8 | Address of this node, sent as the first byte |
| sendReq | input | 1 | Request a read reply of `reqLen` bytes |
| errReq | input | 1 | Request an error reply; wins over `sendReq` |
| reqLen | input | LEN_W (8) | Data byte count for a read reply |
| bufData | input | 8 | Data byte from the buffer at `bufIdx`, read in the same cycle |
| bufRd | output | 1 | One-cycle strobe when a data byte is taken |
| bufIdx | output | BIDX_W (8) | Index of the data byte being taken |
| busy | output | 1 | High while a frame is in progress |
| txDrive | output | 1 | High while the block drives the line |
| txLine | output | 1 | Serial line; high impedance when not driving |

## Verification
The bench decodes frames for data lengths 1 to 12 and for 231 and 232. A counter that is wrong at the wide end would truncate the data or misplace the CRC byte. Error replies are checked, including a request where both request lines are high: a design with the wrong priority would send type 0xAA and a non-zero count. `nodeAddr` is changed just after acceptance, and requests are injected in the middle of a frame; a design that does not latch would corrupt the address byte, and one that restarts would disturb the bit stream or stay busy after release. Requests with a count of zero or of MAX_LEN+1 must leave the line released, which catches a bounds check that is off by one.

// File: rtl/rspTxPkg.sv
package rspTxPkg;

  typedef enum logic [2:0] {
    SEL_SRC,
    SEL_TYPE,
    SEL_LEN,
    SEL_DATA,
    SEL_ZERO,
    SEL_CRC
  } byteSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     accept;  // latch request fields, clear CRC
    logic     load;    // load the selected byte into the shifter
    logic     shift;   // advance the shifter by one bit
    byteSel_t sel;     // which byte to load
    logic [1:0] lenPos; // count byte, 0 = most significant
  } txStrobe_t;

  localparam logic [7:0] TYPE_DATA = 8'hAA;
  localparam logic [7:0] TYPE_ERR  = 8'hF0;
  localparam logic [7:0] CRC_POLY  = 8'h31;

  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] din);
    logic [7:0] c;
    c = crcIn ^ din;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rspTxCtrl.sv
module rspTxCtrl
  import rspTxPkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int MAX_LEN      = 232,
  parameter int LEN_W        = 8,
  parameter int BIDX_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendReq,
  input  logic              errReq,
  input  logic [LEN_W-1:0]  reqLen,
  output txStrobe_t         strb,
  output logic              busy,
  output logic              startPhase,
  output logic              bufRd,
  output logic [BIDX_W-1:0] bufIdx
);

  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IDX_W = $clog2(MAX_LEN + 8);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] HDR_LEN  = IDX_W'(6);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA} state_t;

  state_t           state;
  logic [CNT_W-1:0] baudCnt;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             isErr;
  logic             bitEnd;
  logic             reqOk;
  logic             lenOk;

  assign bitEnd = (baudCnt == CNT_LAST);
  assign lenOk  = (reqLen != '0) && (int'(reqLen) <= MAX_LEN);
  assign reqOk  = errReq || (sendReq && lenOk);

  always_comb begin
    strb    = '0;
    nextIdx = (state == ST_START) ? '0 : byteIdx + 1'b1;
    strb.accept = (state == ST_IDLE) && reqOk;
    strb.load   = ((state == ST_START) && bitEnd) ||
                  ((state == ST_DATA) && bitEnd && (bitCnt == 3'd7) && (byteIdx != lastIdx));
    strb.shift  = (state == ST_DATA) && bitEnd && (bitCnt != 3'd7);
    if (nextIdx == '0)                 strb.sel = SEL_SRC;
    else if (nextIdx == IDX_W'(1))     strb.sel = SEL_TYPE;
    else if (nextIdx < HDR_LEN) begin
      strb.sel    = SEL_LEN;
      strb.lenPos = 2'(nextIdx - IDX_W'(2));
    end
    else if (nextIdx == lastIdx)       strb.sel = SEL_CRC;
    else if (isErr)                    strb.sel = SEL_ZERO;
    else                               strb.sel = SEL_DATA;
  end

  assign bufRd      = strb.load && (strb.sel == SEL_DATA);
  assign bufIdx     = BIDX_W'(nextIdx - HDR_LEN);
  assign busy       = (state != ST_IDLE);
  assign startPhase = (state == ST_START);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
      isErr   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.accept) begin
            state   <= ST_START;
            baudCnt <= '0;
            isErr   <= errReq;
            lastIdx <= errReq ? (HDR_LEN + IDX_W'(1)) : (HDR_LEN + IDX_W'(reqLen));
          end
        end
        ST_START: begin
          if (bitEnd) begin
            baudCnt <= '0;
            state   <= ST_DATA;
            bitCnt  <= '0;
            byteIdx <= '0;
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
        default: begin
          if (bitEnd) begin
            baudCnt <= '0;
            if (bitCnt != 3'd7) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (byteIdx == lastIdx) begin
              state <= ST_IDLE;
            end else begin
              byteIdx <= nextIdx;
              bitCnt  <= '0;
            end
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rspTxPath.sv
module rspTxPath
  import rspTxPkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strb,
  input  logic [7:0]       nodeAddr,
  input  logic             errReq,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       bufData,
  output logic             shBit
);

  logic [7:0]       srcReg;
  logic [LEN_W-1:0] lenReg;
  logic             errReg;
  logic [7:0]       shifter;
  logic [7:0]       crcReg;
  logic [31:0]      len32;
  logic [7:0]       byteVal;

  assign len32 = errReg ? 32'd0 : 32'(lenReg);

  always_comb begin
    case (strb.sel)
      SEL_SRC:  byteVal = srcReg;
      SEL_TYPE: byteVal = errReg ? TYPE_ERR : TYPE_DATA;
      SEL_LEN: begin
        case (strb.lenPos)
          2'd0:    byteVal = len32[31:24];
          2'd1:    byteVal = len32[23:16];
          2'd2:    byteVal = len32[15:8];
          default: byteVal = len32[7:0];
        endcase
      end
      SEL_DATA: byteVal = bufData;
      SEL_CRC:  byteVal = crcReg;
      default:  byteVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg  <= '0;
      lenReg  <= '0;
      errReg  <= 1'b0;
      shifter <= '0;
      crcReg  <= '0;
    end else begin
      if (strb.accept) begin
        srcReg <= nodeAddr;
        lenReg <= reqLen;
        errReg <= errReq;
        crcReg <= '0;
      end
      if (strb.load) begin
        shifter <= byteVal;
        if (strb.sel != SEL_CRC) crcReg <= crc8Step(crcReg, byteVal);
      end else if (strb.shift) begin
        shifter <= {1'b0, shifter[7:1]};
      end
    end
  end

  assign shBit = shifter[0];

endmodule

// File: rtl/rspTx.sv
module rspTx
  import rspTxPkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int MAX_LEN      = 232,
  parameter int LEN_W        = $clog2(MAX_LEN + 1),
  parameter int BIDX_W       = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        nodeAddr,
  input  logic              sendReq,
  input  logic              errReq,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        bufData,
  output logic              bufRd,
  output logic [BIDX_W-1:0] bufIdx,
  output logic              busy,
  output logic              txDrive,
  output wire               txLine
);

  txStrobe_t strb;
  logic      startPhase;
  logic      shBit;

  rspTxCtrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .MAX_LEN     (MAX_LEN),
    .LEN_W       (LEN_W),
    .BIDX_W      (BIDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sendReq    (sendReq),
    .errReq     (errReq),
    .reqLen     (reqLen),
    .strb       (strb),
    .busy       (busy),
    .startPhase (startPhase),
    .bufRd      (bufRd),
    .bufIdx     (bufIdx)
  );

  rspTxPath #(
    .LEN_W(LEN_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .nodeAddr (nodeAddr),
    .errReq   (errReq),
    .reqLen   (reqLen),
    .bufData  (bufData),
    .shBit    (shBit)
  );

  assign txDrive = busy;
  assign txLine  = txDrive ? (startPhase ? 1'b0 : shBit) : 1'bz;

endmodule

// File: rtl/rspTxChecker.sv
module rspTxChecker #(
  parameter int CLKS_PER_BIT = 4
) (
  input logic clk,
  input logic rstN,
  input logic sendReq,
  input logic errReq,
  input logic busy,
  input logic txDrive,
  input logic txLine,
  input logic bufRd
);

  localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  logic [PH_W-1:0] phase;

  // bit phase counter, zero in the first cycle of every bit time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   phase <= '0;
    else if (!busy)                              phase <= '0;
    else if (phase == PH_W'(CLKS_PER_BIT - 1))   phase <= '0;
    else                                         phase <= phase + 1'b1;
  end

  assert_start_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (txDrive && !txLine));

  assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase != '0) |-> $stable(txLine));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txDrive);

  assert_busy_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sendReq || errReq));

  assert_buf_read_in_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    bufRd |-> busy);

  assert_buf_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    bufRd |=> !bufRd);

endmodule

bind rspTx rspTxChecker #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sendReq (sendReq),
  .errReq  (errReq),
  .busy    (busy),
  .txDrive (txDrive),
  .txLine  (txLine),
  .bufRd   (bufRd)
);

// File: tb/rspTx_bench.sv
`timescale 1ns/1ps
module rspTx_bench;

  localparam int C       = 4;
  localparam int MAX_LEN = 232;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] nodeAddr = 8'h00;
  logic       sendReq = 1'b0;
  logic       errReq = 1'b0;
  logic [7:0] reqLen = 8'd0;
  logic [7:0] bufData;
  logic       bufRd;
  logic [7:0] bufIdx;
  logic       busy;
  logic       txDrive;
  wire        txLine;
  logic [7:0] seed = 8'h00;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // buffer model: contents are a function of index and seed
  assign bufData = (bufIdx * 8'd13 + 8'd7) ^ seed;

  rspTx #(.CLKS_PER_BIT(C), .MAX_LEN(MAX_LEN)) u_rspTx (
    .clk(clk), .rstN(rstN), .nodeAddr(nodeAddr), .sendReq(sendReq),
    .errReq(errReq), .reqLen(reqLen), .bufData(bufData), .bufRd(bufRd),
    .bufIdx(bufIdx), .busy(busy), .txDrive(txDrive), .txLine(txLine)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crcBits(input logic [7:0] crcIn, input logic [7:0] b);
    logic [7:0] r = crcIn;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h31 : 8'h00);
    end
    return r;
  endfunction

  // one bit time: drop any pending requests after the first edge
  task automatic nextBit();
    for (int k = 0; k < C; k++) begin
      @(posedge clk);
      if (k == 0) begin #1; sendReq = 0; errReq = 0; end
    end
    @(negedge clk);
  endtask

  task automatic runFrame(input bit isErr, input bit both, input logic [7:0] addr, input int n);
    logic [7:0] exp [0:239];
    int nb;
    int dn;
    logic [7:0] crc;
    dn = isErr ? 1 : n;
    nb = 7 + dn;
    exp[0] = addr;
    exp[1] = isErr ? 8'hF0 : 8'hAA;
    exp[2] = isErr ? 8'h00 : 8'(n >> 24);
    exp[3] = isErr ? 8'h00 : 8'(n >> 16);
    exp[4] = isErr ? 8'h00 : 8'(n >> 8);
    exp[5] = isErr ? 8'h00 : 8'(n);
    for (int i = 0; i < dn; i++) exp[6+i] = isErr ? 8'h00 : 8'((i * 13 + 7) ^ seed);
    crc = 8'h00;
    for (int i = 0; i < 6 + dn; i++) crc = crcBits(crc, exp[i]);
    exp[nb-1] = crc;

    @(negedge clk);
    nodeAddr = addr;
    reqLen   = 8'(n);
    sendReq  = !isErr || both;
    errReq   = isErr;
    @(posedge clk);
    #1;
    sendReq  = 0; errReq = 0;
    nodeAddr = ~addr;            // R1: must not affect frame in flight
    repeat (C/2) @(posedge clk);
    @(negedge clk);
    check(txDrive && txLine === 1'b0 && busy, "R6 start low", int'(txLine), 0);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] got = 8'h00;
      for (int t = 0; t < 8; t++) begin
        nextBit();
        got[t] = txLine;          // R6 LSB first, sampled mid-bit
        if (b == 3 && t == 0) begin
          sendReq = 1; errReq = 1;  // R8: request while busy is ignored
        end
      end
      if (b == 0)          check(got == exp[b], "R1 source address", got, exp[b]);
      else if (b == 1)     check(got == exp[b], "R2 type byte", got, exp[b]);
      else if (b < 6)      check(got == exp[b], isErr ? "R4 zero count" : "R3 count byte", got, exp[b]);
      else if (b < nb - 1) check(got == exp[b], isErr ? "R4 zero data" : "R3 data byte", got, exp[b]);
      else                 check(got == exp[b], "R5 crc byte", got, exp[b]);
    end
    nextBit();
    check(!txDrive && !busy, "R7 release after last bit", {txDrive, busy}, 0);
    repeat (3 * C) @(posedge clk);
    @(negedge clk);
    check(!busy && !txDrive, "R8 no restart from ignored request", busy, 0);
  endtask

  task automatic badLen(input int n);
    @(negedge clk);
    reqLen = 8'(n); sendReq = 1;
    @(posedge clk); #1; sendReq = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!busy && !txDrive, "R9 out-of-range count ignored", busy, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !txDrive && !bufRd, "R7 reset state released", busy, 0);
    rstN = 1;
    repeat (2) @(posedge clk);
    for (int n = 1; n <= 12; n++) begin
      seed = 8'(n * 29);
      runFrame(0, 0, 8'(n * 17 + 1), n);
    end
    seed = 8'hC3;
    runFrame(0, 0, 8'hFE, MAX_LEN);
    runFrame(0, 0, 8'h00, MAX_LEN - 1);
    runFrame(1, 0, 8'h42, 0);
    runFrame(1, 0, 8'hFF, 5);
    runFrame(1, 1, 8'h81, 9);      // R2 both requests: error wins
    badLen(0);
    badLen(MAX_LEN + 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule